// File: doc/BRIEF.md
# Codec Control Serial Write Master

This block sends single register writes to one of two audio codec devices over a three-wire control link. The link has one active-low select line per device, a serial clock and a serial data line. A host presents a request carrying a device index, a 5-bit register address and an 8-bit data byte. The block packs these into a 16-bit frame, pulls the chosen select low and shifts the frame out most significant bit first. It then returns every line high and pulses `done` for one cycle.

Every change on the link is paced by an internal phase counter. The counter produces one tick every `PHASE_TICKS` clock cycles, so the settle time between edges is set at build time. Each bit takes three phases: the clock falls, then the data line takes the new bit, then the clock rises. The receiver samples on that rising edge.

The state machine has seven states:

- `S_IDLE`: waits for a request.
- `S_PREP`: holds all lines high for one phase.
- `S_SEL`: the select is low and the clock and data are still high.
- `S_CLK_LO`, `S_DAT`, `S_CLK_HI`: the three phases of one bit.
- `S_REL`: all lines are high again.

The transitions are:

- `S_IDLE` to `S_PREP` when a request is accepted.
- `S_PREP` to `S_SEL`, `S_SEL` to `S_CLK_LO`, `S_CLK_LO` to `S_DAT` and `S_DAT` to `S_CLK_HI`, each on a tick.
- `S_CLK_HI` to `S_CLK_LO` on a tick while bits remain.
- `S_CLK_HI` to `S_REL` on a tick after bit 0.
- `S_REL` to `S_IDLE` on a tick, which also raises `done` for the next cycle.

Top module: `ctl_link_writer`

## Requirements
- R1: During reset and whenever idle, both selects, the clock and the data line are high, `busy` is 0 and `done` is 0.
- R2: The frame is {2'b10, 1'b1, addr[4:0], data[7:0]}: bits 15:14 are the fixed chip address 2, bit 13 is the write flag 1, bits 12:8 are the register address and bits 7:0 are the data byte.
- R3: The frame is sent with exactly 16 rising clock edges, bit 15 first and bit 0 last, and every rising edge happens while a select is low.
- R4: Within a bit, the clock falls, the data line changes one phase later and the clock rises one phase after that. The data line never changes while the clock is high and a select is low.
- R5: After a request is accepted, all lines stay high for exactly one phase (`PHASE_TICKS` cycles) before the select falls.
- R6: Device index 0 drives `sel_n[0]` low and any other index drives `sel_n[1]` low. Both selects are never low together.
- R7: One phase after the 16th rising clock edge, the select and the data line return high together with the clock, which is already high.
- R8: Any two changes on the link lines are separated by a whole, non-zero multiple of `PHASE_TICKS` cycles.
- R9: `busy` rises in the cycle after acceptance and stays high for exactly 51·`PHASE_TICKS` cycles.
- R10: A request presented while `busy` is high is ignored: no second frame follows and the frame in flight is unchanged.
- R11: `done` is high for exactly one cycle, in the cycle after the release phase ends, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request, accepted when idle |
| req_dev | input | DEV_W | Device index (0 selects device 0, any other value selects device 1) |
| req_addr | input | 5 | Register address |
| req_data | input | 8 | Data byte |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when the frame has finished |
| sel_n | output | 2 | Active-low device selects |
| sclk | output | 1 | Serial clock |
| sdat | output | 1 | Serial data |

## Verification
The assertions assume the following about the inputs:

- `req_valid` is a level sampled on the clock, so the request fields need only be valid in the cycle it is high.
- A request may arrive at any time, including mid-frame.
- `PHASE_TICKS` is at least 1.

The stimulus drives a request for exactly one cycle from the falling clock edge, then lets the frame run to `done`. In one directed case it deliberately raises a second, different request during a frame to exercise the ignore rule. Addresses, data bytes and device indices are drawn at random over their full ranges, alongside directed all-zero and all-one frames.

// File: rtl/ctl_link_pkg.sv
package ctl_link_pkg;
    localparam int FRAME_W  = 16;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 8;
    localparam int IDX_W    = $clog2(FRAME_W);
    localparam logic [1:0] CHIP_ID = 2'b10;
    localparam logic       WR_FLAG = 1'b1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREP,
        S_SEL,
        S_CLK_LO,
        S_DAT,
        S_CLK_HI,
        S_REL
    } link_state_t;

    function automatic logic [FRAME_W-1:0] build_frame(
        input logic [ADDR_W-1:0] addr,
        input logic [DATA_W-1:0] data
    );
        return {CHIP_ID, WR_FLAG, addr, data};
    endfunction
endpackage

// File: rtl/link_phase_pacer.sv
module link_phase_pacer #(
    parameter int PHASE_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (PHASE_TICKS > 1) ? $clog2(PHASE_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASE_TICKS - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    generate
        if (PHASE_TICKS > 1) begin : g_spacing
            // R8: ticks never come back to back when a phase spans several cycles
            a_r8_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/link_frame_store.sv
module link_frame_store
    import ctl_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic [IDX_W-1:0]  idx,
    output logic              cur_bit,
    output logic [FRAME_W-1:0] frame_o
);
    logic [FRAME_W-1:0] frame_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (load) begin
            frame_q <= build_frame(addr, data);
        end
    end

    assign cur_bit = frame_q[idx];
    assign frame_o = frame_q;
endmodule

// File: rtl/ctl_link_writer.sv
module ctl_link_writer
    import ctl_link_pkg::*;
#(
    parameter int PHASE_TICKS = 4,
    parameter int DEV_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              done,
    output logic [1:0]        sel_n,
    output logic              sclk,
    output logic              sdat
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(FRAME_W - 1);

    link_state_t        state, nxt;
    logic               tick;
    logic               accept;
    logic [IDX_W-1:0]   bit_idx;
    logic               dev1_q;
    logic               cur_bit;
    logic [FRAME_W-1:0] frame_w;
    logic [1:0]         sel_q;
    logic               sclk_q, sdat_q, done_q;

    assign accept = (state == S_IDLE) && req_valid;

    link_phase_pacer #(.PHASE_TICKS(PHASE_TICKS)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state != S_IDLE),
        .tick  (tick)
    );

    link_frame_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .addr    (req_addr),
        .data    (req_data),
        .idx     (bit_idx),
        .cur_bit (cur_bit),
        .frame_o (frame_w)
    );

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (req_valid) nxt = S_PREP;
            S_PREP:   if (tick) nxt = S_SEL;
            S_SEL:    if (tick) nxt = S_CLK_LO;
            S_CLK_LO: if (tick) nxt = S_DAT;
            S_DAT:    if (tick) nxt = S_CLK_HI;
            S_CLK_HI: if (tick) nxt = (bit_idx == '0) ? S_REL : S_CLK_LO;
            S_REL:    if (tick) nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // state register, bit counter and device latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            bit_idx <= TOP_IDX;
            dev1_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) begin
                bit_idx <= TOP_IDX;
                dev1_q  <= |req_dev;
            end else if (state == S_CLK_HI && tick && bit_idx != '0) begin
                bit_idx <= bit_idx - 1'b1;
            end
        end
    end

    // registered line drivers, set from the state being entered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 2'b11;
            sclk_q <= 1'b1;
            sdat_q <= 1'b1;
            done_q <= 1'b0;
        end else begin
            done_q <= (state == S_REL) && tick;
            unique case (nxt)
                S_SEL: begin
                    sel_q  <= dev1_q ? 2'b01 : 2'b10;
                    sclk_q <= 1'b1;
                    sdat_q <= 1'b1;
                end
                S_CLK_LO: begin
                    sel_q  <= dev1_q ? 2'b01 : 2'b10;
                    sclk_q <= 1'b0;
                end
                S_DAT: begin
                    sel_q  <= dev1_q ? 2'b01 : 2'b10;
                    sclk_q <= 1'b0;
                    sdat_q <= cur_bit;
                end
                S_CLK_HI: begin
                    sel_q  <= dev1_q ? 2'b01 : 2'b10;
                    sclk_q <= 1'b1;
                end
                default: begin
                    sel_q  <= 2'b11;
                    sclk_q <= 1'b1;
                    sdat_q <= 1'b1;
                end
            endcase
        end
    end

    assign busy  = (state != S_IDLE);
    assign done  = done_q;
    assign sel_n = sel_q;
    assign sclk  = sclk_q;
    assign sdat  = sdat_q;

    // R1: idle means every line is released
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (sel_q == 2'b11 && sclk_q && sdat_q));
    // R6: never both devices selected
    a_r6_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q != 2'b00);
    // R3: rising clock edges only inside a selected frame
    a_r3_rise_selected: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_q) |-> (sel_q != 2'b11));
    // R4: data moves only while the clock is low inside a frame
    a_r4_data_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sdat_q) && sel_q != 2'b11) |-> !sclk_q);
    // R10: the latched frame is frozen while a frame runs
    a_r10_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> $stable(frame_w));
    // R11: done is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R11: done never overlaps busy
    a_r11_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy);
endmodule

// File: tb/sim_ctl_link_writer.sv
`timescale 1ns/1ps
module sim_ctl_link_writer;
    localparam int P  = 3;
    localparam int DW = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          req_valid;
    logic [DW-1:0] req_dev;
    logic [4:0]    req_addr;
    logic [7:0]    req_data;
    logic          busy, done, sclk, sdat;
    logic [1:0]    sel_n;

    ctl_link_writer #(.PHASE_TICKS(P), .DEV_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dev(req_dev),
        .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
        .sel_n(sel_n), .sclk(sclk), .sdat(sdat)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [1:0]  p_sel = 2'b11;
    logic        p_sclk = 1'b1, p_sdat = 1'b1;
    int          last_chg, last_fall, last_rise, sel_fall, rel_cyc;
    int          nrise, nframes, gap_err, order_err, both_err;
    logic [15:0] mon_bits;
    logic [1:0]  seen_sel;

    function automatic logic [15:0] exp_frame(input logic [4:0] a, input logic [7:0] d);
        return {2'b10, 1'b1, a, d};
    endfunction

    function automatic logic [1:0] exp_sel(input logic [DW-1:0] dv);
        return (dv == '0) ? 2'b10 : 2'b01;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic mon_step();
        if ((sel_n != p_sel) || (sclk != p_sclk) || (sdat != p_sdat)) begin
            if (last_chg >= 0 && ((cyc - last_chg) == 0 || ((cyc - last_chg) % P) != 0))
                gap_err++;
            last_chg = cyc;
        end
        if (p_sel == 2'b11 && sel_n != 2'b11) begin
            sel_fall = cyc; seen_sel = sel_n; nframes++;
        end
        if (sel_n == 2'b00) both_err++;
        if (!p_sclk && sclk) begin
            mon_bits = {mon_bits[14:0], sdat};
            nrise++;
            if (sel_n == 2'b11) order_err++;
            if (cyc - last_fall != 2 * P) order_err++;
            last_rise = cyc;
        end
        if (p_sclk && !sclk) last_fall = cyc;
        if (sdat != p_sdat && sel_n != 2'b11) begin
            if (sclk || (cyc - last_fall != P)) order_err++;
        end
        if (p_sel != 2'b11 && sel_n == 2'b11 && sclk && sdat) rel_cyc = cyc;
        p_sel = sel_n; p_sclk = sclk; p_sdat = sdat;
    endtask

    task automatic step();
        @(negedge clk);
        mon_step();
    endtask

    task automatic send(input logic [DW-1:0] dv, input logic [4:0] a,
                        input logic [7:0] d, input bit inject);
        int t0;
        int n;
        last_chg = -1; last_fall = 0; last_rise = 0; sel_fall = 0; rel_cyc = 0;
        nrise = 0; nframes = 0; gap_err = 0; order_err = 0; both_err = 0;
        mon_bits = '0; seen_sel = 2'b11;
        req_valid = 1'b1; req_dev = dv; req_addr = a; req_data = d;
        step();
        req_valid = 1'b0;
        t0 = cyc;
        last_chg = t0;
        chk(busy == 1'b1, "R9 busy after accept", int'(busy), 1);
        n = 0;
        while (!done && n < 2000) begin
            if (inject && n == 40) begin
                req_valid = 1'b1; req_dev = ~dv; req_addr = ~a; req_data = ~d;
            end
            if (inject && n == 41) req_valid = 1'b0;
            step();
            n++;
        end
        chk(done == 1'b1, "R11 done seen", int'(done), 1);
        chk(cyc - t0 == 51 * P, "R9 busy length", cyc - t0, 51 * P);
        chk(busy == 1'b0, "R11 busy low with done", int'(busy), 0);
        chk(mon_bits == exp_frame(a, d), "R2 frame content", int'(mon_bits), int'(exp_frame(a, d)));
        chk(nrise == 16, "R3 rising edge count", nrise, 16);
        chk(seen_sel == exp_sel(dv), "R6 select choice", int'(seen_sel), int'(exp_sel(dv)));
        chk(both_err == 0, "R6 both selects low", both_err, 0);
        chk(order_err == 0, "R4 bit phase order", order_err, 0);
        chk(gap_err == 0, "R8 phase spacing", gap_err, 0);
        chk(sel_fall - t0 == P, "R5 lead-in phase", sel_fall - t0, P);
        chk(rel_cyc - last_rise == P, "R7 release timing", rel_cyc - last_rise, P);
        chk(sel_n == 2'b11 && sclk && sdat, "R7 lines high after frame",
            int'({sel_n, sclk, sdat}), 15);
        step();
        chk(done == 1'b0, "R11 done one cycle", int'(done), 0);
        if (inject) begin
            repeat (60) step();
            chk(nframes == 1, "R10 request while busy ignored", nframes, 1);
            chk(busy == 1'b0, "R10 no second frame busy", int'(busy), 0);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; req_valid = 1'b0; req_dev = '0; req_addr = '0; req_data = '0;
        last_chg = -1;
        repeat (3) step();
        chk(sel_n == 2'b11 && sclk && sdat, "R1 lines in reset", int'({sel_n, sclk, sdat}), 15);
        chk(!busy && !done, "R1 flags in reset", int'({busy, done}), 0);
        rst_n = 1'b1;
        step();
        chk(sel_n == 2'b11 && sclk && sdat && !busy, "R1 idle after reset",
            int'({sel_n, sclk, sdat, busy}), 30);
        send(2'd0, 5'h00, 8'h00, 1'b0);
        send(2'd3, 5'h1f, 8'hff, 1'b0);
        send(2'd1, 5'h15, 8'ha5, 1'b1);
        send(2'd2, 5'h0a, 8'h5a, 1'b0);
        for (int i = 0; i < 16; i++) begin
            send(DW'($urandom_range(0, 3)), 5'($urandom_range(0, 31)),
                 8'($urandom_range(0, 255)), 1'b0);
            repeat (int'($urandom_range(0, 3))) step();
        end
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule